// File: doc/BRIEF.md
# Signed Timestamp Latency Compensator

This block corrects a precision-time timestamp by a programmable extra latency before the timestamp is written into a timing packet or passed on to the receive path. A timestamp is a 64-bit value made of a 48-bit whole-nanosecond field above a 16-bit fraction field. The fraction field counts in units of 1/65536 ns. The latency is a 32-bit sign-magnitude word. Bit 31 is the sign, and a set sign bit means the latency is subtracted. Bits [30:16] hold whole nanoseconds and bits [15:0] hold fractions of a nanosecond in the same 1/65536 ns unit. For example, +2.5 ns is 0x00028000, +5 ns is 0x00050000 and −2.5 ns is 0x80028000.

Each timestamp arrives with a valid strobe. It comes with the correction-field bytes and extension bytes that travel with it, and with a flag that marks a one-step insertion. The corrected timestamp and the two byte fields come out exactly one cycle later, on registered outputs. The same correction is applied to one-step and two-step timestamps. A debug control changes what is inserted for one-step work: instead of the computed values, every timestamp byte becomes 0xAA, every correction-field byte becomes 0xBB and every extension byte becomes 0xCC. Packet parsing, field placement and checksum repair belong to neighbouring logic.

Top module: `ts_latency_comp`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ts_valid_o` is 0 and `ts_o`, `corr_o` and `ext_o` are all zero.
- R2: `ts_valid_o` equals the value `ts_valid_i` had one cycle earlier, including for back-to-back strobes.
- R3: With sign bit 31 clear, `ts_o` is `ts_i` plus the latency magnitude `{lat_word_i[30:16] ns, lat_word_i[15:0] fraction}`. A fraction sum of 65536 or more carries into the nanosecond field at bit 16.
- R4: With sign bit 31 set, `ts_o` is `ts_i` minus the magnitude. A fraction shortfall borrows one nanosecond.
- R5: A magnitude of zero returns `ts_i` unchanged, whether the sign bit is 0 or 1.
- R6: The correction wraps modulo 2^64. All-ones plus 1 fraction unit gives zero, and zero minus 1 fraction unit gives all-ones.
- R7: For a two-step timestamp (`one_step_i` = 0), `ts_o` is the corrected value, and `corr_o` and `ext_o` equal the inputs, whatever the value of `dbg_fill_i`.
- R8: For a one-step timestamp with `dbg_fill_i` = 0, `ts_o` is the corrected value, and `corr_o` and `ext_o` equal the inputs.
- R9: For a one-step timestamp with `dbg_fill_i` = 1, every byte of `ts_o` is 0xAA, every byte of `corr_o` is 0xBB and every byte of `ext_o` is 0xCC.
- R10: In a cycle after `ts_valid_i` was 0, `ts_o`, `corr_o` and `ext_o` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid_i | input | 1 | Input timestamp strobe |
| ts_i | input | 64 | Timestamp: [63:16] ns, [15:0] fraction |
| one_step_i | input | 1 | 1 = one-step insertion, 0 = two-step |
| corr_i | input | 64 | Correction-field bytes travelling with the timestamp |
| ext_i | input | 32 | Extension bytes travelling with the timestamp |
| lat_word_i | input | 32 | Sign-magnitude extra latency |
| dbg_fill_i | input | 1 | Debug marker-byte substitution for one-step fields |
| ts_valid_o | output | 1 | Output strobe, one cycle after input |
| ts_o | output | 64 | Corrected timestamp or marker bytes |
| corr_o | output | 64 | Correction-field bytes or marker bytes |
| ext_o | output | 32 | Extension bytes or marker bytes |

## Verification
The bench builds the block with its default parameters: a 48-bit nanosecond field, a 16-bit fraction, a 15-bit latency nanosecond field, eight correction bytes and four extension bytes. With these values the carry and borrow across bit 16 can be forced with small fractions. The full 64-bit wraparound can be reached by driving an all-ones or all-zero timestamp. The marker substitution can be checked byte by byte across all three field widths. Latencies near the 15-bit nanosecond limit are also applied, so the full magnitude range is exercised.

// File: rtl/tslc_pkg.sv
package tslc_pkg;
  // Marker bytes substituted in debug fill mode, one per inserted field class
  localparam logic [7:0] FILL_TS   = 8'hAA;
  localparam logic [7:0] FILL_CORR = 8'hBB;
  localparam logic [7:0] FILL_EXT  = 8'hCC;

  typedef enum logic {STEP_TWO = 1'b0, STEP_ONE = 1'b1} step_e;
endpackage

// File: rtl/tslc_lat_decode.sv
module tslc_lat_decode #(
  parameter int LAT_NS_W = 15,
  parameter int FRAC_W   = 16,
  parameter int TS_W     = 64
) (
  input  logic [LAT_NS_W+FRAC_W:0] lat_word,
  output logic                     neg,
  output logic [TS_W-1:0]          mag
);
  localparam int MAG_W = LAT_NS_W + FRAC_W;

  always_comb begin
    neg = lat_word[MAG_W];
    mag = '0;
    mag[MAG_W-1:0] = lat_word[MAG_W-1:0];
  end
endmodule

// File: rtl/tslc_ts_adder.sv
module tslc_ts_adder #(
  parameter int NS_W   = 48,
  parameter int FRAC_W = 16,
  localparam int TS_W  = NS_W + FRAC_W
) (
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] mag,
  input  logic            neg,
  output logic [TS_W-1:0] res
);
  logic [FRAC_W:0] frac_add, frac_sub;
  logic [NS_W-1:0] ns_add, ns_sub;

  // Fraction stage first; its top bit is the carry (add) or borrow (sub)
  always_comb begin
    frac_add = {1'b0, ts[FRAC_W-1:0]} + {1'b0, mag[FRAC_W-1:0]};
    frac_sub = {1'b0, ts[FRAC_W-1:0]} - {1'b0, mag[FRAC_W-1:0]};
    ns_add   = ts[TS_W-1:FRAC_W] + mag[TS_W-1:FRAC_W]
             + {{(NS_W-1){1'b0}}, frac_add[FRAC_W]};
    ns_sub   = ts[TS_W-1:FRAC_W] - mag[TS_W-1:FRAC_W]
             - {{(NS_W-1){1'b0}}, frac_sub[FRAC_W]};
    res      = neg ? {ns_sub, frac_sub[FRAC_W-1:0]}
                   : {ns_add, frac_add[FRAC_W-1:0]};
  end
endmodule

// File: rtl/tslc_byte_fill.sv
module tslc_byte_fill #(
  parameter int         NBYTES = 8,
  parameter logic [7:0] FILL   = 8'h00
) (
  input  logic              en,
  input  logic [NBYTES*8-1:0] din,
  output logic [NBYTES*8-1:0] dout
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[b*8 +: 8] = en ? FILL : din[b*8 +: 8];
  end
endmodule

// File: rtl/ts_latency_comp.sv
module ts_latency_comp #(
  parameter int NS_W       = 48,
  parameter int FRAC_W     = 16,
  parameter int LAT_NS_W   = 15,
  parameter int CORR_BYTES = 8,
  parameter int EXT_BYTES  = 4,
  localparam int TS_W      = NS_W + FRAC_W,
  localparam int LAT_W     = LAT_NS_W + FRAC_W + 1,
  localparam int CORR_W    = CORR_BYTES * 8,
  localparam int EXT_W     = EXT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ts_valid_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              one_step_i,
  input  logic [CORR_W-1:0] corr_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [LAT_W-1:0]  lat_word_i,
  input  logic              dbg_fill_i,
  output logic              ts_valid_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [CORR_W-1:0] corr_o,
  output logic [EXT_W-1:0]  ext_o
);
  import tslc_pkg::*;

  localparam int TS_BYTES = TS_W / 8;

  logic              lat_neg;
  logic [TS_W-1:0]   lat_mag;
  logic [TS_W-1:0]   ts_adj;
  logic              fill_en;
  logic [TS_W-1:0]   ts_nxt;
  logic [CORR_W-1:0] corr_nxt;
  logic [EXT_W-1:0]  ext_nxt;

  assign fill_en = dbg_fill_i && (step_e'(one_step_i) == STEP_ONE);

  tslc_lat_decode #(.LAT_NS_W(LAT_NS_W), .FRAC_W(FRAC_W), .TS_W(TS_W)) u_dec (
    .lat_word (lat_word_i),
    .neg      (lat_neg),
    .mag      (lat_mag)
  );

  tslc_ts_adder #(.NS_W(NS_W), .FRAC_W(FRAC_W)) u_add (
    .ts  (ts_i),
    .mag (lat_mag),
    .neg (lat_neg),
    .res (ts_adj)
  );

  tslc_byte_fill #(.NBYTES(TS_BYTES), .FILL(FILL_TS)) u_fill_ts (
    .en (fill_en), .din (ts_adj), .dout (ts_nxt)
  );

  tslc_byte_fill #(.NBYTES(CORR_BYTES), .FILL(FILL_CORR)) u_fill_corr (
    .en (fill_en), .din (corr_i), .dout (corr_nxt)
  );

  tslc_byte_fill #(.NBYTES(EXT_BYTES), .FILL(FILL_EXT)) u_fill_ext (
    .en (fill_en), .din (ext_i), .dout (ext_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_valid_o <= 1'b0;
      ts_o       <= '0;
      corr_o     <= '0;
      ext_o      <= '0;
    end else begin
      ts_valid_o <= ts_valid_i;
      if (ts_valid_i) begin
        ts_o   <= ts_nxt;
        corr_o <= corr_nxt;
        ext_o  <= ext_nxt;
      end
    end
  end
endmodule

// File: rtl/ts_latency_comp_chk.sv
module ts_latency_comp_chk #(
  parameter int NS_W       = 48,
  parameter int FRAC_W     = 16,
  parameter int LAT_NS_W   = 15,
  parameter int CORR_BYTES = 8,
  parameter int EXT_BYTES  = 4,
  localparam int TS_W      = NS_W + FRAC_W,
  localparam int MAG_W     = LAT_NS_W + FRAC_W,
  localparam int LAT_W     = MAG_W + 1,
  localparam int CORR_W    = CORR_BYTES * 8,
  localparam int EXT_W     = EXT_BYTES * 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ts_valid_i,
  input logic [TS_W-1:0]   ts_i,
  input logic              one_step_i,
  input logic [CORR_W-1:0] corr_i,
  input logic [EXT_W-1:0]  ext_i,
  input logic [LAT_W-1:0]  lat_word_i,
  input logic              dbg_fill_i,
  input logic              ts_valid_o,
  input logic [TS_W-1:0]   ts_o,
  input logic [CORR_W-1:0] corr_o,
  input logic [EXT_W-1:0]  ext_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  logic [TS_W-1:0] mag_w;
  assign mag_w = {{(TS_W-MAG_W){1'b0}}, lat_word_i[MAG_W-1:0]};

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> ts_valid_o == $past(ts_valid_i));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !ts_valid_o);

  p_add_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ts_valid_i && !lat_word_i[MAG_W] && !(dbg_fill_i && one_step_i))
    |-> ts_o == $past(ts_i + mag_w));

  p_sub_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ts_valid_i && lat_word_i[MAG_W] && !(dbg_fill_i && one_step_i))
    |-> ts_o == $past(ts_i - mag_w));

  p_zero_pass_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ts_valid_i && lat_word_i[MAG_W-1:0] == '0 && !(dbg_fill_i && one_step_i))
    |-> ts_o == $past(ts_i));

  p_two_step_r7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ts_valid_i && !one_step_i)
    |-> corr_o == $past(corr_i) && ext_o == $past(ext_i));

  p_fill_r9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ts_valid_i && one_step_i && dbg_fill_i)
    |-> ts_o == {(TS_W/8){8'hAA}} && corr_o == {CORR_BYTES{8'hBB}}
        && ext_o == {EXT_BYTES{8'hCC}});

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!ts_valid_i && !rst)
    |-> $stable(ts_o) && $stable(corr_o) && $stable(ext_o));
endmodule

bind ts_latency_comp ts_latency_comp_chk #(
  .NS_W(NS_W), .FRAC_W(FRAC_W), .LAT_NS_W(LAT_NS_W),
  .CORR_BYTES(CORR_BYTES), .EXT_BYTES(EXT_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .ts_valid_i(ts_valid_i), .ts_i(ts_i),
  .one_step_i(one_step_i), .corr_i(corr_i), .ext_i(ext_i),
  .lat_word_i(lat_word_i), .dbg_fill_i(dbg_fill_i),
  .ts_valid_o(ts_valid_o), .ts_o(ts_o), .corr_o(corr_o), .ext_o(ext_o)
);

// File: tb/sim_ts_latency_comp.sv
`timescale 1ns/1ps
module sim_ts_latency_comp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ts_valid_i = 1'b0;
  logic [63:0] ts_i = '0;
  logic        one_step_i = 1'b0;
  logic [63:0] corr_i = '0;
  logic [31:0] ext_i = '0;
  logic [31:0] lat_word_i = '0;
  logic        dbg_fill_i = 1'b0;
  logic        ts_valid_o;
  logic [63:0] ts_o;
  logic [63:0] corr_o;
  logic [31:0] ext_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ts_latency_comp u0 (
    .clk(clk), .rst(rst), .ts_valid_i(ts_valid_i), .ts_i(ts_i),
    .one_step_i(one_step_i), .corr_i(corr_i), .ext_i(ext_i),
    .lat_word_i(lat_word_i), .dbg_fill_i(dbg_fill_i),
    .ts_valid_o(ts_valid_o), .ts_o(ts_o), .corr_o(corr_o), .ext_o(ext_o)
  );

  function automatic logic [63:0] model(input logic [63:0] t, input logic [31:0] l);
    logic [63:0] m = {33'b0, l[30:0]};
    return l[31] ? t - m : t + m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Present one strobe at a falling edge; results are checked at the next falling edge
  task automatic send(input logic [63:0] t, input logic [31:0] l, input logic os,
                      input logic dbg, input logic [63:0] c, input logic [31:0] e);
    @(negedge clk);
    ts_valid_i = 1'b1; ts_i = t; lat_word_i = l; one_step_i = os;
    dbg_fill_i = dbg; corr_i = c; ext_i = e;
    @(negedge clk);
    ts_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {63'b0, ts_valid_o}, 64'd0);
    chk("R1 ts", ts_o, 64'd0);
    chk("R1 corr", corr_o, 64'd0);
    chk("R1 ext", {32'b0, ext_o}, 64'd0);
  endtask

  task automatic t_add_carry;
    send({48'd10, 16'hC000}, 32'h0002_8000, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R3 carry", ts_o, {48'd13, 16'h4000});
    chk("R2 valid", {63'b0, ts_valid_o}, 64'd1);
    send({48'd100, 16'h0001}, 32'h0005_0000, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R3 whole ns", ts_o, {48'd105, 16'h0001});
    send(64'h0000_1234_5678_9ABC, 32'h7FFF_FFFF, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R3 max magnitude", ts_o, model(64'h0000_1234_5678_9ABC, 32'h7FFF_FFFF));
  endtask

  task automatic t_sub_borrow;
    send({48'd10, 16'h4000}, 32'h8002_8000, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R4 borrow", ts_o, {48'd7, 16'hC000});
    send(64'h0000_00FF_0000_8000, 32'h8100_0001, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R4 sub", ts_o, model(64'h0000_00FF_0000_8000, 32'h8100_0001));
  endtask

  task automatic t_zero;
    send(64'hDEAD_BEEF_0123_4567, 32'h0000_0000, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R5 plus zero", ts_o, 64'hDEAD_BEEF_0123_4567);
    send(64'hDEAD_BEEF_0123_4568, 32'h8000_0000, 1'b1, 1'b0, 64'h1, 32'h2);
    chk("R5 minus zero", ts_o, 64'hDEAD_BEEF_0123_4568);
  endtask

  task automatic t_wrap;
    send(64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R6 wrap up", ts_o, 64'd0);
    send(64'd0, 32'h8000_0001, 1'b0, 1'b0, 64'h1, 32'h2);
    chk("R6 wrap down", ts_o, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_two_step;
    send({48'd50, 16'h0}, 32'h0002_8000, 1'b0, 1'b1, 64'h0102_0304_0506_0708, 32'hA1B2_C3D4);
    chk("R7 ts", ts_o, {48'd52, 16'h8000});
    chk("R7 corr", corr_o, 64'h0102_0304_0506_0708);
    chk("R7 ext", {32'b0, ext_o}, {32'b0, 32'hA1B2_C3D4});
  endtask

  task automatic t_one_step;
    send({48'd50, 16'h0}, 32'h8000_8000, 1'b1, 1'b0, 64'h1112_1314_1516_1718, 32'h5566_7788);
    chk("R8 ts", ts_o, {48'd49, 16'h8000});
    chk("R8 corr", corr_o, 64'h1112_1314_1516_1718);
    chk("R8 ext", {32'b0, ext_o}, {32'b0, 32'h5566_7788});
  endtask

  task automatic t_fill;
    send({48'd50, 16'h0}, 32'h0002_8000, 1'b1, 1'b1, 64'h1112_1314_1516_1718, 32'h5566_7788);
    chk("R9 ts", ts_o, 64'hAAAA_AAAA_AAAA_AAAA);
    chk("R9 corr", corr_o, 64'hBBBB_BBBB_BBBB_BBBB);
    chk("R9 ext", {32'b0, ext_o}, {32'b0, 32'hCCCC_CCCC});
  endtask

  task automatic t_hold;
    send({48'd7, 16'h7}, 32'h0, 1'b0, 1'b0, 64'h77, 32'h88);
    @(negedge clk);
    ts_i = 64'h1; lat_word_i = 32'h0001_0000; one_step_i = 1'b1;
    dbg_fill_i = 1'b1; corr_i = 64'h99; ext_i = 32'h99;
    @(negedge clk);
    @(negedge clk);
    chk("R10 ts", ts_o, {48'd7, 16'h7});
    chk("R10 corr", corr_o, 64'h77);
    chk("R10 ext", {32'b0, ext_o}, 64'h88);
    chk("R2 idle", {63'b0, ts_valid_o}, 64'd0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    dbg_fill_i = 1'b0; one_step_i = 1'b0; lat_word_i = 32'h0001_0000;
    for (int k = 0; k < 3; k++) begin
      ts_valid_i = 1'b1; ts_i = 64'(k) << 16;
      @(negedge clk);
      chk("R2 stream valid", {63'b0, ts_valid_o}, 64'd1);
      chk("R2 stream data", ts_o, (64'(k) << 16) + 64'h1_0000);
    end
    ts_valid_i = 1'b0;
    @(negedge clk);
    chk("R2 stream end", {63'b0, ts_valid_o}, 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_add_carry;
    t_sub_borrow;
    t_zero;
    t_wrap;
    t_two_step;
    t_one_step;
    t_fill;
    t_hold;
    t_stream;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule